// File: doc/BRIEF.md
# Spanning-Conversion ADC Read Controller

This block is the master side of a three-wire serial link to a 16-bit successive-approximation converter. The converter runs in a mode where the read spans the conversion and no busy flag is given. For each transaction, the block raises the conversion-start line and holds it high for a fixed conversion time. It then drops the line and waits a fixed output-enable delay. After that it runs the serial clock and samples the converter's data line on every rising edge. While clocking, it sends a fresh configuration word to the converter, most significant bit first.

The most significant result bit is already present on the data line once the enable delay has passed, before any clock edge. Each falling edge of the serial clock then moves the line to the next bit. The first rising edge therefore captures the MSB, and a full 16 clock periods are run so that the 16th rising edge latches the LSB.

When bit 0 of the configuration word is 0, the converter sends its configuration back right after the data word. The block then runs extra clock periods and captures that word in the same transaction.

A request is offered on a valid/ready pair. Ready is high only while the block is idle, so the host holds valid until ready is seen and no request is lost. The result side has no back-pressure: the result registers update together with a one-cycle done strobe, and the host takes the data on that strobe. The conversion time, enable delay and clock half-period are parameters counted in system clocks.

Top module: `adc_span_reader`

## Requirements
- R1: A request is accepted only on a clock where `start_valid` and `start_ready` are both high. `start_ready` is low from acceptance until the clock on which `done` rises. A `start_valid` pulse while ready is low has no effect on any output.
- R2: On acceptance, `adc_cnv` goes high for exactly T_CONV clocks and then low. It stays low until the next accepted request.
- R3: `adc_sck` idles low. Its first rising edge comes T_EN + SCK_HALF clocks after `adc_cnv` falls. This guarantees the enable delay has elapsed before any edge.
- R4: `adc_sck` runs with SCK_HALF clocks low, then SCK_HALF clocks high, per period. It gives 16 periods without readback and 30 periods with readback (16 data bits plus 14 configuration bits). It ends low.
- R5: `adc_sdo` is sampled at every rising edge of `adc_sck`. The first sample is the MSB, which is present before any falling edge. The 16-bit code is assembled MSB first, so full-scale, midscale and zero codes all come back intact.
- R6: `adc_din` carries the 14-bit configuration MSB first. Its first bit is valid before the first rising edge. It changes only while `adc_sck` is low, so it is stable through every high phase.
- R7: Bit 0 of `start_cfg` equal to 0 enables readback. The 14 bits sampled after the data word are then returned on `result_cfg` and `result_cfg_ok` is high. With bit 0 equal to 1, `result_cfg` is 0 and `result_cfg_ok` is low.
- R8: `done` is high for one clock, exactly T_CONV + T_EN + 2*SCK_HALF*(number of periods) clocks after the acceptance edge. `result_code` and `result_cfg` are valid from that clock.
- R9: `adc_cnv` and `adc_sck` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Request to run one conversion-read transaction |
| start_ready | output | 1 | High while idle and able to accept a request |
| start_cfg | input | CFG_W | Configuration word sent this transaction; bit 0 = 0 requests readback |
| adc_cnv | output | 1 | Conversion-start line to the converter |
| adc_sck | output | 1 | Serial clock to the converter, idles low |
| adc_din | output | 1 | Configuration bits to the converter |
| adc_sdo | input | 1 | Serial data from the converter |
| done | output | 1 | One-cycle strobe marking new results |
| result_code | output | DATA_W | Captured conversion result |
| result_cfg | output | CFG_W | Configuration read back, or 0 |
| result_cfg_ok | output | 1 | High when `result_cfg` holds a readback |

## Verification
The bench builds the block with T_CONV = 10, T_EN = 3 and SCK_HALF = 2. These short values keep a 30-period readback transaction under 140 clocks, so many transactions fit in one run. Every phase boundary is still spread over several clocks, so off-by-one errors in the conversion, enable or half-period counters show up on the per-clock compare.

The converter model drives the inverse of the MSB until the enable delay has passed. Clocking too early therefore corrupts full-scale and zero codes in a way the bench sees. The model also moves to the next bit only on falling edges, so a controller that runs 15 periods or samples on the wrong edge loses a bit.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_WAIT  = 2'd2,
    ST_SHIFT = 2'd3
  } rd_state_e;
endpackage

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CFG_W    = 14,
  parameter int T_CONV   = 10,
  parameter int T_EN     = 3,
  parameter int SCK_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic rdbk,
  output logic idle,
  output logic cnv,
  output logic sck,
  output logic smp,
  output logic load,
  output logic adv,
  output logic fin
);
  localparam int TOT  = DATA_W + CFG_W;
  localparam int BW   = $clog2(TOT + 1);
  localparam int TMAX = (T_CONV > T_EN) ? ((T_CONV > SCK_HALF) ? T_CONV : SCK_HALF)
                                        : ((T_EN > SCK_HALF) ? T_EN : SCK_HALF);
  localparam int CW   = $clog2(TMAX + 1);

  rd_state_e       st;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   bitn;
  logic [BW-1:0]   nb;
  logic            hi_end;
  logic            last;

  assign idle   = (st == ST_IDLE);
  assign smp    = (st == ST_SHIFT) && !sck && (cnt == CW'(SCK_HALF - 1));
  assign hi_end = (st == ST_SHIFT) &&  sck && (cnt == CW'(SCK_HALF - 1));
  assign last   = hi_end && (bitn == nb - BW'(1));
  assign adv    = hi_end && !last;
  assign fin    = last;
  assign load   = (st == ST_WAIT) && (cnt == CW'(T_EN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      bitn <= '0;
      nb   <= '0;
      cnv  <= 1'b0;
      sck  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (go) begin
            st  <= ST_CONV;
            cnt <= '0;
            cnv <= 1'b1;
            nb  <= rdbk ? BW'(TOT) : BW'(DATA_W);
          end
        end
        ST_CONV: begin
          if (cnt == CW'(T_CONV - 1)) begin
            cnv <= 1'b0;
            cnt <= '0;
            st  <= ST_WAIT;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_WAIT: begin
          if (load) begin
            cnt  <= '0;
            bitn <= '0;
            st   <= ST_SHIFT;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_SHIFT: begin
          if (cnt == CW'(SCK_HALF - 1)) begin
            cnt <= '0;
            sck <= ~sck;
            if (last)     st   <= ST_IDLE;
            else if (sck) bitn <= bitn + BW'(1);
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3
  sck_only_in_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> (st == ST_SHIFT));

  // R2
  cnv_fall_to_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv) |-> (st == ST_WAIT));

  // R4
  bit_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SHIFT) |-> (bitn < nb));

  // R4
  sck_low_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sck);
endmodule

// File: rtl/adc_rd_txsh.sv
module adc_rd_txsh #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic [W-1:0] word,
  input  logic         load,
  input  logic         adv,
  input  logic         fin,
  output logic         dout
);
  logic [W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      dout <= 1'b0;
    end else if (cap) begin
      sr   <= word;
      dout <= 1'b0;
    end else if (load || adv) begin
      dout <= sr[W-1];
      sr   <= {sr[W-2:0], 1'b0};
    end else if (fin) begin
      dout <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_rd_rxsh.sv
module adc_rd_rxsh #(
  parameter int W = 30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         smp,
  input  logic         sdo,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (smp) q <= {q[W-2:0], sdo};
  end
endmodule

// File: rtl/adc_span_reader.sv
module adc_span_reader #(
  parameter int DATA_W   = 16,
  parameter int CFG_W    = 14,
  parameter int T_CONV   = 10,
  parameter int T_EN     = 3,
  parameter int SCK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [CFG_W-1:0]  start_cfg,
  output logic              adc_cnv,
  output logic              adc_sck,
  output logic              adc_din,
  input  logic              adc_sdo,
  output logic              done,
  output logic [DATA_W-1:0] result_code,
  output logic [CFG_W-1:0]  result_cfg,
  output logic              result_cfg_ok
);
  localparam int TOT = DATA_W + CFG_W;

  logic           accept;
  logic           rdbk_req;
  logic           rdbk_q;
  logic           smp, load, adv, fin;
  logic [TOT-1:0] rx;

  assign accept   = start_valid && start_ready;
  assign rdbk_req = ~start_cfg[0];

  adc_rd_seq #(
    .DATA_W(DATA_W), .CFG_W(CFG_W), .T_CONV(T_CONV),
    .T_EN(T_EN), .SCK_HALF(SCK_HALF)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .go(accept), .rdbk(rdbk_req),
    .idle(start_ready), .cnv(adc_cnv), .sck(adc_sck),
    .smp(smp), .load(load), .adv(adv), .fin(fin)
  );

  adc_rd_txsh #(.W(CFG_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .cap(accept), .word(start_cfg),
    .load(load), .adv(adv), .fin(fin), .dout(adc_din)
  );

  adc_rd_rxsh #(.W(TOT)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(accept), .smp(smp),
    .sdo(adc_sdo), .q(rx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdbk_q        <= 1'b0;
      done          <= 1'b0;
      result_code   <= '0;
      result_cfg    <= '0;
      result_cfg_ok <= 1'b0;
    end else begin
      done <= fin;
      if (accept) rdbk_q <= rdbk_req;
      if (fin) begin
        result_cfg_ok <= rdbk_q;
        if (rdbk_q) begin
          result_code <= rx[TOT-1 -: DATA_W];
          result_cfg  <= rx[CFG_W-1:0];
        end else begin
          result_code <= rx[DATA_W-1:0];
          result_cfg  <= '0;
        end
      end
    end
  end

  // R9
  cnv_sck_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(adc_cnv && adc_sck));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !start_ready);

  // R6
  din_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_sck && $past(adc_sck)) |-> $stable(adc_din));
endmodule

// File: tb/adc_span_reader_tb.sv
module adc_span_reader_tb;
  localparam int DW = 16;
  localparam int CW = 14;
  localparam int TC = 10;
  localparam int TE = 3;
  localparam int H  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_valid = 1'b0;
  logic          start_ready;
  logic [CW-1:0] start_cfg = '0;
  logic          adc_cnv, adc_sck, adc_din;
  logic          adc_sdo = 1'b0;
  logic          done;
  logic [DW-1:0] result_code;
  logic [CW-1:0] result_cfg;
  logic          result_cfg_ok;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #10 clk = ~clk;

  adc_span_reader #(
    .DATA_W(DW), .CFG_W(CW), .T_CONV(TC), .T_EN(TE), .SCK_HALF(H)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid),
    .start_ready(start_ready), .start_cfg(start_cfg),
    .adc_cnv(adc_cnv), .adc_sck(adc_sck), .adc_din(adc_din),
    .adc_sdo(adc_sdo), .done(done), .result_code(result_code),
    .result_cfg(result_cfg), .result_cfg_ok(result_cfg_ok)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      if (n_fail < 40)
        $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // converter model state
  logic [DW-1:0] m_code = '0;
  logic [CW-1:0] m_cfg  = '0;
  int  en_cnt = 0;
  int  idx = 0;
  logic sck_prev = 1'b0;
  logic [CW-1:0] din_cap = '0;
  int  rises = 0;

  // reference timing model
  int  k = 0;
  bit  run = 0;
  bit  m_rb = 0;
  int  n_done = 0;

  function automatic int periods(input bit rb);
    return rb ? (DW + CW) : DW;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      run = 0;
    end else if (start_valid && start_ready) begin
      run  = 1;
      k    = 0;
      m_rb = ~start_cfg[0];
      rises = 0;
      din_cap = '0;
    end else if (run) begin
      k++;
      if (k > TC + TE + 2*H*periods(m_rb)) run = 0;
    end
  end

  always @(negedge clk) begin
    logic [DW+CW-1:0] stream;
    int E, S;
    stream = {m_code, m_cfg};
    // converter data line behaviour
    if (adc_cnv) begin
      en_cnt = 0;
      idx = 0;
    end else if (en_cnt < 1000) begin
      en_cnt++;
    end
    if (sck_prev && !adc_sck) idx++;
    if (!sck_prev && adc_sck) begin
      if (rises < CW) din_cap = {din_cap[CW-2:0], adc_din};
      rises++;
    end
    sck_prev = adc_sck;
    if (en_cnt < TE)         adc_sdo = ~stream[DW+CW-1];
    else if (idx < DW + CW)  adc_sdo = stream[DW+CW-1-idx];
    else                     adc_sdo = 1'b0;

    // per-clock comparison
    if (rst_n) begin
      S = TC + TE;
      E = S + 2*H*periods(m_rb);
      // R2
      check("R2 cnv", adc_cnv, run && k < TC);
      // R3 R4
      check("R4 sck", adc_sck, run && k >= S && k < E && (((k - S) / H) % 2 == 1));
      // R1
      check("R1 ready", start_ready, !(run && k < E));
      // R8
      check("R8 done", done, run && k == E);
      if (done) n_done++;
    end
  end

  task automatic txn(input logic [DW-1:0] code, input logic [CW-1:0] cfg);
    bit rb;
    rb = ~cfg[0];
    m_code = code;
    m_cfg  = cfg;
    @(negedge clk); #1;
    start_valid = 1'b1;
    start_cfg   = cfg;
    do @(posedge clk); while (!start_ready);
    #1 start_valid = 1'b0;
    do @(negedge clk); while (!done);
    #2;
    // R5
    check("R5 code", result_code, code);
    // R7
    check("R7 cfg_ok", result_cfg_ok, rb);
    check("R7 cfg", result_cfg, rb ? cfg : '0);
    // R4
    check("R4 periods", rises, periods(rb));
    // R6
    check("R6 din", din_cap, cfg);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    check("R3 reset sck", adc_sck, 1'b0);
    check("R2 reset cnv", adc_cnv, 1'b0);
    check("R8 reset done", done, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 reset ready", start_ready, 1'b1);

    // R5 full-scale, midscale and zero, with and without readback
    txn(16'hFFFF, 14'h3C49);
    txn(16'h8000, 14'h3C48);
    txn(16'h0000, 14'h3C48);
    txn(16'h7FFF, 14'h2A55);
    txn(16'hA5C3, 14'h1E36);
    txn(16'h0001, 14'h3FFF);

    // R1 start pulses while busy are ignored
    fork
      txn(16'h5A5A, 14'h2222);
      begin
        repeat (20) @(negedge clk);
        #1 start_valid = 1'b1;
        start_cfg = 14'h0001;
        repeat (8) @(negedge clk);
        #1 start_valid = 1'b0;
      end
    join
    repeat (5) @(negedge clk);
    check("R1 no extra txn", n_done, 7);
    check("R1 idle after", start_ready, 1'b1);

    txn(16'hC001, 14'h0FF0);
    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule